// File: doc/BRIEF.md
# Firmware Image Stream Verifier

This block watches a boot-image byte stream while it passes through, for example on its way into flash. It pulls the header fields out of the first eight bytes. It then follows a variable number of length-prefixed segments. After the last segment it checks the zero padding that aligns the image. Finally it compares the closing checksum byte with a running XOR over the segment payload bytes. Nothing is stored. The block keeps only the parse state, a few header registers and one checksum byte.

Bytes arrive on a valid/ready interface. A byte is consumed on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while an image is being parsed. The source may drop `in_valid` for any number of cycles without changing the result. When `in_ready` is low, the source must hold its byte. A one-cycle `start` pulse begins a new image and discards whatever was in progress.

The image layout is as follows:
- Header: byte 0 is the magic value, byte 1 is the declared segment count, byte 2 is the flash interface mode, byte 3 holds the size code in its upper nibble and the clock code in its lower nibble, and bytes 4..7 hold the entry address.
- Segments: each segment has an 8-byte descriptor (a load address, then a byte length, both little-endian) followed by its payload.
- Tail: zero bytes pad the image, then one checksum byte makes the total length a multiple of 16.

Top module: `fw_image_checker`

## Requirements
- R1: `in_ready` is low out of reset and after `done`. It is high from the cycle after `start` until the byte that ends the check has been consumed. A byte is consumed only on an edge where `in_valid` and `in_ready` are both high.
- R2: If byte 0 is not 0xE9, the check ends with `err_code` = 1 and `pass` = 0.
- R3: After the header has been consumed, `seg_count` equals byte 1, `flash_mode` equals byte 2, `flash_size` equals byte 3 bits [7:4], `flash_freq` equals byte 3 bits [3:0], and `entry_point` equals bytes 4..7 with byte 4 least significant. These values hold until the next `start`.
- R4: The block walks exactly `seg_count` segments. Each segment is an 8-byte descriptor whose bytes 4..7 give a little-endian payload length, followed by that many payload bytes. A count of zero and a length of zero are both legal.
- R5: After the last segment, the byte at stream index i (counting from 0) is the checksum byte if i mod 16 = 15. Otherwise it is padding and must be 0x00. A non-zero padding byte ends the check with `err_code` = 2.
- R6: The expected checksum is 0xEF XOR every payload byte of every segment. Header and descriptor bytes are excluded. If the checksum byte matches, `pass` = 1 and `err_code` = 0. If it differs, `err_code` = 3.
- R7: `in_last` on any consumed byte other than the checksum byte means the image ended short of its declared segments. The check then ends with `err_code` = 4.
- R8: If a checksum byte that matches is consumed without `in_last`, more data follows than the image declares, and the check ends with `err_code` = 5. When more than one fault applies, the lowest code wins. Magic and padding faults take precedence over a short end.
- R9: `done` rises on the cycle after the byte that ends the check is consumed. `done`, `pass` and `err_code` then hold until `start`. `start` clears all three and restarts parsing, even in the middle of an image.
- R10: Idle cycles with `in_valid` low between bytes do not change any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new image |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Block can consume a byte this cycle |
| done | output | 1 | Check finished; result is valid |
| pass | output | 1 | Image passed every check |
| err_code | output | 3 | 0 ok, 1 magic, 2 padding, 3 checksum, 4 short, 5 long |
| seg_count | output | 8 | Declared segment count |
| flash_mode | output | 8 | Flash interface mode byte (0 QIO, 1 QOUT, 2 DIO, 3 DOUT) |
| flash_size | output | 4 | Flash size code |
| flash_freq | output | 4 | Flash clock code |
| entry_point | output | 32 | Entry address |

## Verification
Directed images cover the following layouts:
- zero segments;
- a zero-length segment placed before a non-empty one;
- a payload that ends exactly one byte before the 16-byte boundary, which leaves no padding.

These layouts separate correct descriptor walking and alignment from off-by-one faults in the length or index counters. Single corruptions each map to exactly one error code: a wrong magic byte, one non-zero pad byte, a flipped checksum bit, an early last flag, and a missing last flag. Seeded random images vary the segment count, payload lengths, header bytes and idle gaps. These show that header and descriptor bytes stay out of the checksum and that stalls are harmless. A restart in the middle of an image shows that `start` fully clears the earlier state.

// File: rtl/fw_img_pkg.sv
package fw_img_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_DESC, ST_DATA, ST_PAD, ST_DONE
  } fw_state_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_MAGIC = 3'd1,
    ERR_PAD   = 3'd2,
    ERR_CSUM  = 3'd3,
    ERR_SHORT = 3'd4,
    ERR_LONG  = 3'd5
  } fw_err_e;

  localparam logic [7:0] IMG_MAGIC = 8'hE9;
  localparam logic [7:0] CSUM_SEED = 8'hEF;
endpackage

// File: rtl/fw_mod_counter.sv
module fw_mod_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + 1'b1;
  end

  // R5: position tracking restarts from zero after a clear
  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);
endmodule

// File: rtl/fw_xor_acc.sv
module fw_xor_acc #(
  parameter int         W    = 8,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= SEED;
    else if (clr) acc <= SEED;
    else if (en)  acc <= acc ^ d;
  end

  // R6: only payload bytes may change the running checksum
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !en |=> $stable(acc));
endmodule

// File: rtl/fw_le_shift.sv
module fw_le_shift #(
  parameter int BYTES = 4,
  localparam int W = 8 * BYTES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_nxt
);
  assign q_nxt = {d, q[W-1:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= q_nxt;
  end
endmodule

// File: rtl/fw_image_checker.sv
module fw_image_checker
  import fw_img_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int FIELD_B = 4,
  localparam int WORD_W = 8 * FIELD_B,
  localparam int FC_W   = $clog2(2 * FIELD_B)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              done,
  output logic              pass,
  output logic [2:0]        err_code,
  output logic [7:0]        seg_count,
  output logic [7:0]        flash_mode,
  output logic [3:0]        flash_size,
  output logic [3:0]        flash_freq,
  output logic [WORD_W-1:0] entry_point
);
  fw_state_e        state;
  fw_err_e          err_q, fault;
  logic             fire, is_ck;
  logic [3:0]       idx;
  logic [FC_W-1:0]  fcnt;
  logic [7:0]       seg_left, sizefreq_q, acc;
  logic [LEN_W-1:0] data_left, len_val;
  logic [WORD_W-1:0] len_q, len_nxt, entry_nxt;

  assign in_ready = (state != ST_IDLE) && (state != ST_DONE);
  assign fire     = in_valid && in_ready && !start;
  assign is_ck    = (state == ST_PAD) && (idx == 4'hF);
  assign len_val  = LEN_W'(len_nxt);

  fw_mod_counter #(.W(4)) u_idx (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(fire), .q(idx));

  fw_mod_counter #(.W(FC_W)) u_fcnt (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .inc(fire && (state == ST_HDR || state == ST_DESC)), .q(fcnt));

  fw_xor_acc #(.W(8), .SEED(CSUM_SEED)) u_csum (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .en(fire && state == ST_DATA), .d(in_data), .acc(acc));

  fw_le_shift #(.BYTES(FIELD_B)) u_entry (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .en(fire && state == ST_HDR && fcnt[FC_W-1]), .d(in_data),
    .q(entry_point), .q_nxt(entry_nxt));

  fw_le_shift #(.BYTES(FIELD_B)) u_len (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .en(fire && state == ST_DESC && fcnt[FC_W-1]), .d(in_data),
    .q(len_q), .q_nxt(len_nxt));

  always_comb begin
    fault = ERR_NONE;
    if (state == ST_HDR && fcnt == '0 && in_data != IMG_MAGIC) fault = ERR_MAGIC;
    else if (state == ST_PAD && !is_ck && in_data != 8'h00)    fault = ERR_PAD;
    else if (is_ck && in_data != acc)                          fault = ERR_CSUM;
    else if (is_ck && !in_last)                                fault = ERR_LONG;
    else if (!is_ck && in_last)                                fault = ERR_SHORT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; done <= 1'b0; pass <= 1'b0; err_q <= ERR_NONE;
      seg_left <= '0; data_left <= '0; seg_count <= '0;
      flash_mode <= '0; sizefreq_q <= '0;
    end else if (start) begin
      state <= ST_HDR; done <= 1'b0; pass <= 1'b0; err_q <= ERR_NONE;
      seg_left <= '0; data_left <= '0;
    end else if (fire) begin
      if (fault != ERR_NONE) begin
        state <= ST_DONE; done <= 1'b1; err_q <= fault;
      end else if (is_ck) begin
        state <= ST_DONE; done <= 1'b1; pass <= 1'b1;
      end else begin
        unique case (state)
          ST_HDR: begin
            if (fcnt == FC_W'(1)) begin
              seg_count <= in_data;
              seg_left  <= in_data;
            end
            if (fcnt == FC_W'(2)) flash_mode <= in_data;
            if (fcnt == FC_W'(3)) sizefreq_q <= in_data;
            if (fcnt == '1) state <= (seg_left == '0) ? ST_PAD : ST_DESC;
          end
          ST_DESC: begin
            if (fcnt == '1) begin
              if (len_val == '0) begin
                seg_left <= seg_left - 1'b1;
                state    <= (seg_left == 8'd1) ? ST_PAD : ST_DESC;
              end else begin
                data_left <= len_val;
                state     <= ST_DATA;
              end
            end
          end
          ST_DATA: begin
            data_left <= data_left - 1'b1;
            if (data_left == LEN_W'(1)) begin
              seg_left <= seg_left - 1'b1;
              state    <= (seg_left == 8'd1) ? ST_PAD : ST_DESC;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign err_code   = err_q;
  assign flash_size = sizefreq_q[7:4];
  assign flash_freq = sizefreq_q[3:0];

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(err_code) && $stable(pass));
  p_pass_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done && err_code == 3'd0);
  p_no_accept_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  p_ck_position_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> $past(idx) == 4'hF);
endmodule

// File: tb/fw_image_checker_bench.sv
module fw_image_checker_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, done, pass;
  logic [2:0] err_code;
  logic [7:0] seg_count, flash_mode;
  logic [3:0] flash_size, flash_freq;
  logic [31:0] entry_point;

  fw_image_checker u_fw_image_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .done(done), .pass(pass), .err_code(err_code), .seg_count(seg_count),
    .flash_mode(flash_mode), .flash_size(flash_size),
    .flash_freq(flash_freq), .entry_point(entry_point));

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [7:0] img [0:511];
  int img_n, pad_lo, pad_n;
  int lens [0:3];
  bit gaps = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic build(input int nseg);
    int p;
    logic [7:0] ck;
    ck = 8'hEF;
    img[0] = 8'hE9; img[1] = 8'(nseg); img[2] = 8'($urandom_range(0, 3));
    img[3] = 8'($urandom);
    for (int k = 4; k < 8; k++) img[k] = 8'($urandom);
    p = 8;
    for (int s = 0; s < nseg; s++) begin
      for (int k = 0; k < 4; k++) img[p+k] = 8'($urandom);
      for (int k = 0; k < 4; k++) img[p+4+k] = 8'(lens[s] >> (8*k));
      p += 8;
      for (int k = 0; k < lens[s]; k++) begin
        img[p] = 8'($urandom);
        ck ^= img[p];
        p++;
      end
    end
    pad_lo = p;
    while ((p % 16) != 15) begin img[p] = 8'h00; p++; end
    pad_n = p - pad_lo;
    img[p] = ck;
    img_n = p + 1;
  endtask

  task automatic send(input int n, input int last_at);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
          @(negedge clk); in_valid = 1'b0;
        end
      end
      @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == last_at);
      #1;
      if (!in_ready) break;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run(input string tag, input int n, input int last_at,
                     input int exp_err);
    pulse_start();
    send(n, last_at);
    chk({tag, " R9 done"}, done, 1);
    chk({tag, " R6 pass"}, pass, exp_err == 0);
    chk({tag, " R8 err_code"}, err_code, exp_err);
    chk({tag, " R1 ready low after done"}, in_ready, 0);
    if (exp_err != 1) begin
      chk({tag, " R3 seg_count"}, seg_count, img[1]);
      chk({tag, " R3 flash_mode"}, flash_mode, img[2]);
      chk({tag, " R3 flash_size"}, flash_size, img[3][7:4]);
      chk({tag, " R3 flash_freq"}, flash_freq, img[3][3:0]);
      chk({tag, " R3 entry"}, entry_point, {img[7], img[6], img[5], img[4]});
    end
    repeat (2) @(negedge clk);
    chk({tag, " R9 hold"}, {done, pass, err_code}, {1'b1, exp_err == 0, 3'(exp_err)});
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset ready", in_ready, 0);
    chk("R9 reset done", done, 0);
    chk("R9 reset pass/err", {pass, err_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ready", in_ready, 0);

    // R4 zero segments
    build(0); run("R4 noseg", img_n, img_n - 1, 0);
    // R4 zero-length segment then payload
    lens[0] = 0; lens[1] = 5; build(2); run("R4 zerolen", img_n, img_n - 1, 0);
    // R5 no padding at all
    lens[0] = 15; build(1);
    chk("R5 no pad layout", pad_n, 0);
    run("R5 nopad", img_n, img_n - 1, 0);
    // R2 bad magic
    lens[0] = 6; build(1); img[0] = 8'hE8; run("R2 magic", img_n, img_n - 1, 1);
    // R5 non-zero pad byte
    lens[0] = 3; build(1); img[25] = 8'h40; run("R5 pad", img_n, img_n - 1, 2);
    // R6 checksum flipped
    lens[0] = 9; build(1); img[img_n-1] ^= 8'h01; run("R6 csum", img_n, img_n - 1, 3);
    // R7 ends early (inside zero padding)
    lens[0] = 4; lens[1] = 4; build(2); run("R7 short", img_n, img_n - 5, 4);
    // R8 no last flag on checksum, extra data following
    lens[0] = 7; build(1); img[img_n] = 8'h11; run("R8 long", img_n + 1, -1, 5);
    // R9 restart mid-image
    lens[0] = 20; lens[1] = 3; build(2);
    pulse_start(); send(14, -1);
    chk("R9 mid busy", {done, in_ready}, 2'b01);
    run("R9 restart", img_n, img_n - 1, 0);

    // R10 random images with idle gaps, mixed faults
    gaps = 1'b1;
    for (int t = 0; t < 40; t++) begin
      int nseg, kind;
      nseg = $urandom_range(0, 3);
      for (int s = 0; s < 4; s++) lens[s] = $urandom_range(0, 24);
      build(nseg);
      kind = $urandom_range(0, 3);
      case (kind)
        0: run("R10 rand good", img_n, img_n - 1, 0);
        1: begin img[img_n-1] ^= 8'h80; run("R6 rand csum", img_n, img_n - 1, 3); end
        2: run("R7 rand short", img_n, $urandom_range(8, img_n - 2), 4);
        default: begin img[img_n] = 8'h00; run("R8 rand long", img_n + 1, -1, 5); end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule